// File: doc/BRIEF.md
# Ring Mailbox Bridge

This block sits on a processor's data-memory port and splits each load or store between two targets. Addresses below the local RAM limit go straight to a synchronous data RAM. A six-word register window just above that limit is a mailbox for a unidirectional ring node. Through it the processor can see status, read the last message delivered to it, stage and launch an outgoing message, and learn how many nodes the ring holds.

To send, software writes the destination word and then the body word. Writing the body launches the message toward the ring node. The node holds it until it accepts it with a ready handshake. To receive, software polls status and reads the delivered destination and data words. Reading the data word frees the mailbox for the next arrival. The ring cannot be stalled, so an arrival that finds the mailbox still full is dropped and a sticky flag records the loss.

Every read answers exactly one cycle after it is issued, whether it targets RAM, the window or an unmapped address. This keeps the pipeline's load timing uniform.

Top module: `ring_mailbox_bridge`

## Requirements
- R1: An access to an address below 0x3000 drives ram_en in the same cycle, with ram_we equal to cpu_we, ram_addr equal to cpu_addr[13:2] and ram_wdata equal to cpu_wdata. Read data from the RAM appears on cpu_rdata in the following cycle.
- R2: cpu_rvalid is high in exactly the cycle after each read request (cpu_req high, cpu_we low), and low after writes and idle cycles.
- R3: A read of 0x3014 returns the parameter NODE_COUNT (default 8). Writes to 0x3014 have no effect.
- R4: Reads of addresses at or above 0x3018 return zero, and writes to them have no effect. No address at or above 0x3000 ever asserts ram_en.
- R5: A read of 0x3000 returns status: bit 0 is receive pending, bit 1 is transmit busy, bit 2 is receive overflow, and all other bits are zero. Reading status changes nothing.
- R6: A write to 0x300C stages the destination word. A write to 0x3010 while not busy launches the message. From the next cycle tx_valid is high, tx_dest holds the staged word and tx_body holds the written word, and status bit 1 is set.
- R7: While tx_valid is high and tx_ready is low, tx_valid, tx_dest and tx_body hold steady. In the cycle after tx_valid and tx_ready are both high, tx_valid is low and status bit 1 is clear.
- R8: While busy, writes to 0x300C and 0x3010 are ignored. Neither the tx outputs nor their readback at 0x300C and 0x3010 change.
- R9: An rx_valid cycle while nothing is pending stores rx_addr and rx_data, which are then readable at 0x3004 and 0x3008, and sets status bit 0.
- R10: A read of 0x3008 clears status bit 0. A read of 0x3004 does not.
- R11: An arrival while a message is pending and 0x3008 is not read in the same cycle is dropped. The stored message is kept and status bit 2 is set, and it stays set until reset.
- R12: An arrival in the same cycle as a read of 0x3008 returns the old data and stores the new message. Status bit 0 stays set and bit 2 is not set.
- R13: During and after reset, tx_valid and cpu_rvalid are low and status reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor data access request |
| cpu_we | input | 1 | Access is a store |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rvalid | output | 1 | Load data valid (one cycle after request) |
| cpu_rdata | output | 32 | Load data |
| ram_en | output | 1 | Local RAM access enable |
| ram_we | output | 1 | Local RAM write enable |
| ram_addr | output | 12 | Local RAM word address |
| ram_wdata | output | 32 | Local RAM write data |
| ram_rdata | input | 32 | Local RAM read data (one cycle latency) |
| tx_valid | output | 1 | Outgoing message offered to ring node |
| tx_ready | input | 1 | Ring node accepts outgoing message |
| tx_dest | output | 32 | Outgoing destination word |
| tx_body | output | 32 | Outgoing body word |
| rx_valid | input | 1 | Ring node delivers a message this cycle |
| rx_addr | input | 32 | Delivered destination word |
| rx_data | input | 32 | Delivered body word |

## Verification
The hardest case to reach is a delivery that lands in the very cycle the processor reads the receive data word. The clear and the new capture then compete inside one edge, and a wrong priority either loses the message or reports a false overflow. The bench drives rx_valid and the load of 0x3008 from the same falling edge. It checks that the old body is returned, that status still shows pending without overflow, and that a second read returns the new body. A separate back-to-back delivery without the read then shows the drop and the sticky flag.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  typedef enum logic [1:0] {RG_NONE = 2'd0, RG_RAM = 2'd1, RG_WIN = 2'd2} region_e;

  localparam int unsigned WIN_REGS = 6;
  localparam int unsigned IDX_W    = $clog2(WIN_REGS);

  typedef enum logic [IDX_W-1:0] {
    IX_STATUS = 3'd0,
    IX_RXADDR = 3'd1,
    IX_RXDATA = 3'd2,
    IX_TXADDR = 3'd3,
    IX_TXDATA = 3'd4,
    IX_NODES  = 3'd5
  } win_idx_e;

  localparam int unsigned ST_RXPEND = 0;
  localparam int unsigned ST_TXBUSY = 1;
  localparam int unsigned ST_OVFL   = 2;
endpackage

// File: rtl/rmb_rst_sync.sv
module rmb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rmb_decode.sv
module rmb_decode
  import rmb_pkg::*;
#(
  parameter int unsigned            ADDR_W    = 32,
  parameter logic [ADDR_W-1:0]      RAM_BYTES = 'h3000,
  parameter logic [ADDR_W-1:0]      WIN_BASE  = 'h3000
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output win_idx_e          idx
);
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(WIN_REGS * 4);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = addr - WIN_BASE;
    region = RG_NONE;
    idx    = IX_STATUS;
    if (addr < RAM_BYTES) begin
      region = RG_RAM;
    end else if ((addr >= WIN_BASE) && (off < WIN_SPAN)) begin
      region = RG_WIN;
      idx    = win_idx_e'(off[IDX_W+1:2]);
    end
  end
endmodule

// File: rtl/rmb_mailbox.sv
module rmb_mailbox
  import rmb_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NODE_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  win_idx_e          idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_dest,
  output logic [DATA_W-1:0] tx_body,
  output logic [DATA_W-1:0] rdata
);
  logic              pend_q, pend_n;
  logic              ovf_q, ovf_n;
  logic              busy_q, busy_n;
  logic [DATA_W-1:0] rxa_q, rxd_q, dest_q, body_q;

  logic rd_rx, stage_en, launch, rx_take;

  // next-state logic
  always_comb begin
    rd_rx    = rd_en && (idx == IX_RXDATA);
    stage_en = wr_en && (idx == IX_TXADDR) && !busy_q;
    launch   = wr_en && (idx == IX_TXDATA) && !busy_q;
    rx_take  = rx_valid && (!pend_q || rd_rx);

    if (rx_valid)   pend_n = 1'b1;
    else if (rd_rx) pend_n = 1'b0;
    else            pend_n = pend_q;

    ovf_n  = ovf_q | (rx_valid && pend_q && !rd_rx);
    busy_n = busy_q ? !tx_ready : launch;
  end

  // read mux
  always_comb begin
    rdata = '0;
    unique case (idx)
      IX_STATUS: begin
        rdata[ST_RXPEND] = pend_q;
        rdata[ST_TXBUSY] = busy_q;
        rdata[ST_OVFL]   = ovf_q;
      end
      IX_RXADDR: rdata = rxa_q;
      IX_RXDATA: rdata = rxd_q;
      IX_TXADDR: rdata = dest_q;
      IX_TXDATA: rdata = body_q;
      IX_NODES:  rdata = DATA_W'(NODE_COUNT);
      default:   rdata = '0;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      busy_q <= 1'b0;
      rxa_q  <= '0;
      rxd_q  <= '0;
      dest_q <= '0;
      body_q <= '0;
    end else begin
      pend_q <= pend_n;
      ovf_q  <= ovf_n;
      busy_q <= busy_n;
      if (stage_en) dest_q <= wdata;
      if (launch)   body_q <= wdata;
      if (rx_take) begin
        rxa_q <= rx_addr;
        rxd_q <= rx_data;
      end
    end
  end

  assign tx_valid = busy_q;
  assign tx_dest  = dest_q;
  assign tx_body  = body_q;
endmodule

// File: rtl/rmb_resp.sv
module rmb_resp
  import rmb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  region_e           region,
  input  logic [DATA_W-1:0] win_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic              vld_q;
  logic              from_ram_q, from_ram_n;
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    from_ram_n = (region == RG_RAM);
    data_n     = (region == RG_WIN) ? win_rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q      <= 1'b0;
      from_ram_q <= 1'b0;
      data_q     <= '0;
    end else begin
      vld_q <= rd_fire;
      if (rd_fire) begin
        from_ram_q <= from_ram_n;
        data_q     <= data_n;
      end
    end
  end

  assign cpu_rvalid = vld_q;
  assign cpu_rdata  = from_ram_q ? ram_rdata : data_q;
endmodule

// File: rtl/ring_mailbox_bridge.sv
module ring_mailbox_bridge
  import rmb_pkg::*;
#(
  parameter int unsigned        ADDR_W     = 32,
  parameter int unsigned        DATA_W     = 32,
  parameter logic [ADDR_W-1:0]  RAM_BYTES  = 'h3000,
  parameter logic [ADDR_W-1:0]  WIN_BASE   = 'h3000,
  parameter int unsigned        NODE_COUNT = 8,
  localparam int unsigned       RAM_AW     = $clog2(RAM_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_dest,
  output logic [DATA_W-1:0] tx_body,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_addr,
  input  logic [DATA_W-1:0] rx_data
);
  logic              rst_n_int;
  region_e           region;
  win_idx_e          idx;
  logic              win_wr, win_rd, rd_fire;
  logic [DATA_W-1:0] win_rdata;

  rmb_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rmb_decode #(
    .ADDR_W    (ADDR_W),
    .RAM_BYTES (RAM_BYTES),
    .WIN_BASE  (WIN_BASE)
  ) u_dec (
    .addr   (cpu_addr),
    .region (region),
    .idx    (idx)
  );

  always_comb begin
    rd_fire = cpu_req && !cpu_we;
    win_wr  = cpu_req && cpu_we && (region == RG_WIN);
    win_rd  = rd_fire && (region == RG_WIN);
  end

  rmb_mailbox #(
    .DATA_W     (DATA_W),
    .NODE_COUNT (NODE_COUNT)
  ) u_mbox (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (win_wr),
    .rd_en    (win_rd),
    .idx      (idx),
    .wdata    (cpu_wdata),
    .rx_valid (rx_valid),
    .rx_addr  (rx_addr),
    .rx_data  (rx_data),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_dest  (tx_dest),
    .tx_body  (tx_body),
    .rdata    (win_rdata)
  );

  rmb_resp #(
    .DATA_W (DATA_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .rd_fire    (rd_fire),
    .region     (region),
    .win_rdata  (win_rdata),
    .ram_rdata  (ram_rdata),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata)
  );

  assign ram_en    = cpu_req && (region == RG_RAM);
  assign ram_we    = cpu_we;
  assign ram_addr  = cpu_addr[RAM_AW+1:2];
  assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/rmb_checker.sv
module rmb_checker #(
  parameter int unsigned       ADDR_W     = 32,
  parameter int unsigned       DATA_W     = 32,
  parameter logic [ADDR_W-1:0] RAM_BYTES  = 'h3000,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 'h3000,
  parameter int unsigned       NODE_COUNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              cpu_rvalid,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              ram_en,
  input logic              ram_we,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_dest,
  input logic [DATA_W-1:0] tx_body
);
  localparam logic [ADDR_W-1:0] WIN_END  = WIN_BASE + ADDR_W'(24);
  localparam logic [ADDR_W-1:0] NODE_ADR = WIN_BASE + ADDR_W'(20);

  AST_RVALID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we) |=> cpu_rvalid); // R2

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_req && !cpu_we) |=> !cpu_rvalid); // R2

  AST_RAM_WRITE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && (cpu_addr < RAM_BYTES)) |-> (ram_en && ram_we && (ram_wdata == cpu_wdata))); // R1

  AST_RAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr >= RAM_BYTES) |-> !ram_en); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && (cpu_addr >= WIN_END)) |=> (cpu_rdata == '0)); // R4

  AST_NODE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && (cpu_addr == NODE_ADR)) |=> (cpu_rdata == DATA_W'(NODE_COUNT))); // R3

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_dest) && $stable(tx_body))); // R7

  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid); // R7
endmodule

bind ring_mailbox_bridge rmb_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .RAM_BYTES  (RAM_BYTES),
  .WIN_BASE   (WIN_BASE),
  .NODE_COUNT (NODE_COUNT)
) u_rmb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_we     (cpu_we),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rvalid (cpu_rvalid),
  .cpu_rdata  (cpu_rdata),
  .ram_en     (ram_en),
  .ram_we     (ram_we),
  .ram_wdata  (ram_wdata),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_dest    (tx_dest),
  .tx_body    (tx_body)
);

// File: tb/tb_ring_mailbox_bridge.sv
module tb_ring_mailbox_bridge;
  localparam int unsigned NODES = 8;
  localparam logic [31:0] A_STATUS = 32'h3000;
  localparam logic [31:0] A_RXADDR = 32'h3004;
  localparam logic [31:0] A_RXDATA = 32'h3008;
  localparam logic [31:0] A_TXADDR = 32'h300C;
  localparam logic [31:0] A_TXDATA = 32'h3010;
  localparam logic [31:0] A_NODES  = 32'h3014;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        ram_en, ram_we;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata = '0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [31:0] tx_dest, tx_body;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_addr = '0, rx_data = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  ring_mailbox_bridge #(.NODE_COUNT(NODES)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dest(tx_dest), .tx_body(tx_body),
    .rx_valid(rx_valid), .rx_addr(rx_addr), .rx_data(rx_data)
  );

  // synchronous RAM model
  logic [31:0] mem [3072];
  always_ff @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      ram_rdata <= mem[ram_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    d = cpu_rdata;
    chk("R2 rvalid after read", {31'd0, cpu_rvalid}, 32'd1);
    cpu_req = 1'b0;
  endtask

  task automatic deliver(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_addr = a; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;   // write data, or expected read data
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0000, 32'hDEAD_BEEF},  // R1 low edge
    '{1'b1, 32'h0000_2FFC, 32'h1234_5678},  // R1 top RAM word
    '{1'b0, 32'h0000_0000, 32'hDEAD_BEEF},  // R1
    '{1'b0, 32'h0000_2FFC, 32'h1234_5678},  // R1
    '{1'b1, 32'h0000_3014, 32'hFFFF_FFFF},  // R3 write ignored
    '{1'b0, 32'h0000_3014, 32'h0000_0008},  // R3
    '{1'b1, 32'h0000_3018, 32'hAAAA_5555},  // R4 unmapped write
    '{1'b0, 32'h0000_3018, 32'h0000_0000},  // R4
    '{1'b0, 32'h0001_0000, 32'h0000_0000},  // R4 far unmapped
    '{1'b1, 32'h0000_0100, 32'h0BAD_F00D},  // R1
    '{1'b0, 32'h0000_0100, 32'h0BAD_F00D},  // R1
    '{1'b0, 32'h0000_0000, 32'hDEAD_BEEF}   // R1 untouched by other writes
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R13 reset state
    repeat (3) @(negedge clk);
    chk("R13 tx_valid in reset", {31'd0, tx_valid}, 32'd0);
    chk("R13 rvalid in reset", {31'd0, cpu_rvalid}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_STATUS, r); chk("R13 status after reset", r, 32'd0);

    // vector table: RAM, node count, unmapped (R1 R3 R4)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = VECS[i].we; cpu_addr = VECS[i].addr; cpu_wdata = VECS[i].data;
      #1;
      chk($sformatf("R1/R4 ram_en row %0d", i), {31'd0, ram_en},
          {31'd0, (VECS[i].addr < 32'h3000)});
      @(negedge clk);
      if (!VECS[i].we) begin
        chk($sformatf("R1/R3/R4 rdata row %0d", i), cpu_rdata, VECS[i].data);
        chk($sformatf("R2 rvalid row %0d", i), {31'd0, cpu_rvalid}, 32'd1);
      end else begin
        chk($sformatf("R2 no rvalid after write row %0d", i), {31'd0, cpu_rvalid}, 32'd0);
      end
      cpu_req = 1'b0; cpu_we = 1'b0;
    end

    // R6 launch
    wr(A_TXADDR, 32'h0000_0005);
    chk("R6 no launch on address write", {31'd0, tx_valid}, 32'd0);
    wr(A_TXDATA, 32'hCAFE_0001);
    chk("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R6 tx_dest", tx_dest, 32'h0000_0005);
    chk("R6 tx_body", tx_body, 32'hCAFE_0001);
    rd(A_STATUS, r); chk("R5 status busy", r, 32'h2);

    // R8 writes while busy ignored
    wr(A_TXADDR, 32'h0000_0009);
    wr(A_TXDATA, 32'hBBBB_BBBB);
    chk("R8 tx_dest kept", tx_dest, 32'h0000_0005);
    chk("R8 tx_body kept", tx_body, 32'hCAFE_0001);
    rd(A_TXADDR, r); chk("R8 readback dest", r, 32'h0000_0005);
    rd(A_TXDATA, r); chk("R8 readback body", r, 32'hCAFE_0001);

    // R7 hold then accept
    repeat (3) begin
      @(negedge clk);
      chk("R7 held valid", {31'd0, tx_valid}, 32'd1);
    end
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    chk("R7 released after accept", {31'd0, tx_valid}, 32'd0);
    rd(A_STATUS, r); chk("R7 busy cleared", r, 32'h0);
    wr(A_TXDATA, 32'h0000_0077);
    chk("R6 relaunch dest", tx_dest, 32'h0000_0005);
    chk("R6 relaunch body", tx_body, 32'h0000_0077);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;

    // R9 / R10 receive
    deliver(32'h0000_0003, 32'hD100_0001);
    rd(A_STATUS, r); chk("R9 pending set", r, 32'h1);
    rd(A_RXADDR, r); chk("R9 rx addr", r, 32'h0000_0003);
    rd(A_STATUS, r); chk("R10 addr read keeps pending", r, 32'h1);
    rd(A_RXDATA, r); chk("R9 rx data", r, 32'hD100_0001);
    rd(A_STATUS, r); chk("R10 pending cleared", r, 32'h0);

    // R12 arrival in the same cycle as the data read
    deliver(32'h0000_0004, 32'hD400_0004);
    @(negedge clk);
    rx_valid = 1'b1; rx_addr = 32'h0000_0006; rx_data = 32'hD500_0005;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A_RXDATA;
    @(negedge clk);
    r = cpu_rdata;
    rx_valid = 1'b0; cpu_req = 1'b0;
    chk("R12 old data returned", r, 32'hD400_0004);
    rd(A_STATUS, r); chk("R12 pending kept, no overflow", r, 32'h1);
    rd(A_RXADDR, r); chk("R12 new addr stored", r, 32'h0000_0006);
    rd(A_RXDATA, r); chk("R12 new data stored", r, 32'hD500_0005);

    // R11 overflow
    deliver(32'h0000_0002, 32'hD200_0002);
    deliver(32'h0000_0007, 32'hD300_0003);
    rd(A_STATUS, r); chk("R11 overflow flagged", r, 32'h5);
    rd(A_RXDATA, r); chk("R11 first message kept", r, 32'hD200_0002);
    rd(A_STATUS, r); chk("R11 overflow sticky", r, 32'h4);

    // R13 reset clears busy and overflow
    wr(A_TXDATA, 32'h0000_0099);
    chk("R6 busy before reset", {31'd0, tx_valid}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R13 tx_valid on reset", {31'd0, tx_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_STATUS, r); chk("R13 status cleared", r, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule